// File: doc/BRIEF.md
# Addressed Serial Register Loader

This block is the programming port of a dual frequency synthesizer controller. Software writes settings over three wires: a data line, a serial clock and a load-enable strobe. Each rising edge of the serial clock shifts one bit into a 20-bit register, most significant bit first. When load-enable rises, the two bits shifted in last form an address. That address picks one of four control latches, and the 18 bits shifted in before it are copied into that latch. The four latches drive parallel outputs for the divider and mode logic downstream.

The serial pins are asynchronous. Each one passes through a two-flop synchronizer into the system clock domain, and the rising edges of the serial clock and load-enable are found by edge detection. The system clock must run at least four times faster than the serial clock. Every latch write comes with a one-cycle update strobe and the index of the latch written, so downstream logic can pick up the new setting. A sticky framing-error flag records any word that was not exactly 20 bits long.

Top module: `serial_cfg_loader`

## Requirements
- R1: On each rising edge of `ser_clk`, the value on `ser_data` shifts into bit 0 of the 20-bit shift register and the older bits move one place toward bit 19. A 20-bit word is therefore sent most significant bit first.
- R2: On a rising edge of `ser_le`, the two bits shifted in last (register bits 1:0, value n from 0 to 3) select latch n. That latch takes register bits 19:2, so the first payload bit sent becomes bit 17 of `cfg_q[n]`.
- R3: A latch keeps its value until a word addressed to it is loaded. A load leaves the other three latches unchanged.
- R4: Each rising edge of `ser_le` produces exactly one cycle of `upd_stb` high. `upd_idx` equals the selected latch index in that cycle.
- R5: A word of any length is decoded from the current register contents. After a long word, the last 20 bits sent are used. After a short word, bits left from earlier shifts fill the upper positions.
- R6: If the number of `ser_clk` rising edges since the previous load is not exactly 20 when `ser_le` rises, `frame_err` goes high. It stays high until `err_clr` is asserted. If a new error and a clear happen in the same cycle, the error wins.
- R7: While `rst` is high at a clock edge, the shift register, all four latches, `upd_stb` and `frame_err` are cleared to zero.
- R8: A latch write, together with its strobe, appears within four system clock cycles after `ser_le` rises at the pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_le | input | 1 | Load enable, asynchronous; rising edge loads a latch |
| err_clr | input | 1 | Clears the framing-error flag |
| cfg_q | output | 4x18 | Four control latches, `cfg_q[n]` is latch n |
| upd_stb | output | 1 | One-cycle pulse on each latch write |
| upd_idx | output | 2 | Index of the latch written |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
The bench writes each of the four latches with a distinct payload and checks that the other three are not touched. A design with a wrong address decode or bit order would put the payload in the wrong latch or reverse its bits. It then sends a 22-bit word and an 18-bit word. Both must be decoded from the bits actually in the register and must set the error flag. A design that resets the register on load-enable, or that keeps only the first 20 bits, would produce different latch values. The bench also checks that the flag survives a later good word, that a clear removes it, and that each load gives one strobe pulse, not zero or two.

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
  parameter int WORD_W = 20,
  parameter int ADDR_W = 2,
  localparam int PAY_W = WORD_W - ADDR_W,
  localparam int NLAT  = 1 << ADDR_W,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        ser_data,
  input  logic                        ser_clk,
  input  logic                        ser_le,
  input  logic                        err_clr,
  output logic [NLAT-1:0][PAY_W-1:0]  cfg_q,
  output logic                        upd_stb,
  output logic [ADDR_W-1:0]           upd_idx,
  output logic                        frame_err
);
  logic [1:0]        dat_s;
  logic [2:0]        sck_s, le_s;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  nbits;
  logic              shift_en, load_en;
  logic [ADDR_W-1:0] addr;

  assign shift_en = sck_s[1] & ~sck_s[2];
  assign load_en  = le_s[1] & ~le_s[2];
  assign addr     = shreg[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    dat_s <= {dat_s[0], ser_data};
    sck_s <= {sck_s[1:0], ser_clk};
    le_s  <= {le_s[1:0], ser_le};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      nbits <= '0;
    end else if (shift_en) begin
      shreg <= {shreg[WORD_W-2:0], dat_s[1]};
      if (nbits != CNT_W'(WORD_W + 1)) nbits <= nbits + 1'b1;
    end else if (load_en) begin
      nbits <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      upd_stb   <= 1'b0;
      upd_idx   <= '0;
      frame_err <= 1'b0;
    end else begin
      upd_stb <= load_en;
      if (load_en) begin
        cfg_q[addr] <= shreg[WORD_W-1:ADDR_W];
        upd_idx     <= addr;
      end
      if (load_en && nbits != CNT_W'(WORD_W)) frame_err <= 1'b1;
      else if (err_clr)                       frame_err <= 1'b0;
    end
  end
endmodule

module serial_cfg_loader_chk #(
  parameter int WORD_W = 20,
  parameter int ADDR_W = 2,
  localparam int PAY_W = WORD_W - ADDR_W,
  localparam int NLAT  = 1 << ADDR_W
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       err_clr,
  input logic [NLAT-1:0][PAY_W-1:0] cfg_q,
  input logic                       upd_stb,
  input logic [ADDR_W-1:0]          upd_idx,
  input logic                       frame_err
);
  p_stb_single_r4: assert property (@(posedge clk) disable iff (rst)
    upd_stb |=> !upd_stb);

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !upd_stb |-> $stable(cfg_q));

  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    p_other_untouched_r2: assert property (@(posedge clk) disable iff (rst)
      (upd_stb && upd_idx != ADDR_W'(i)) |-> $stable(cfg_q[i]));
  end

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_err && !err_clr) |=> frame_err);

  p_reset_clears_r7: assert property (@(posedge clk)
    rst |=> (cfg_q == '0 && !frame_err && !upd_stb));
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .err_clr(err_clr), .cfg_q(cfg_q),
  .upd_stb(upd_stb), .upd_idx(upd_idx), .frame_err(frame_err));

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;
  logic clk = 0, rst = 1, ser_data = 0, ser_clk = 0, ser_le = 0, err_clr = 0;
  logic [3:0][17:0] cfg_q;
  logic upd_stb, frame_err;
  logic [1:0] upd_idx;
  int checks = 0, fails = 0;
  logic [19:0] model = '0;
  logic [3:0][17:0] exp_cfg = '0;
  int stb_cnt;
  logic [1:0] seen_idx;

  serial_cfg_loader uut (.clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_le(ser_le), .err_clr(err_clr), .cfg_q(cfg_q), .upd_stb(upd_stb),
    .upd_idx(upd_idx), .frame_err(frame_err));

  always #10 clk = ~clk;

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = w[i];
      repeat (3) @(negedge clk);
      ser_clk = 1;
      model = {model[18:0], w[i]};
      repeat (3) @(negedge clk);
      ser_clk = 0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic load();
    stb_cnt = 0;
    ser_le = 1;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (upd_stb) begin stb_cnt++; seen_idx = upd_idx; end
    end
    ser_le = 0;
    repeat (3) @(negedge clk);
    exp_cfg[model[1:0]] = model[19:2];
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++)
      chk(cfg_q[k] == exp_cfg[k], req, 32'(cfg_q[k]), 32'(exp_cfg[k]));
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(cfg_q == '0, "R7 latches", 32'(cfg_q[0]), 0);
    chk(!frame_err && !upd_stb, "R7 flags", {frame_err, upd_stb}, 0);
  endtask

  task automatic t_write(input logic [17:0] pay, input logic [1:0] a);
    shift_bits({pay, a}, 20);
    load();
    chk(stb_cnt == 1, "R4 strobe count", stb_cnt, 1);
    chk(seen_idx == a, "R4 index", seen_idx, a);
    check_all("R1 R2 R3 latch contents");
  endtask

  task automatic t_long();
    shift_bits(32'h2_ABCDE, 22);
    load();
    check_all("R5 long word");
    chk(frame_err, "R6 long sets error", frame_err, 1);
  endtask

  task automatic t_sticky_clear();
    t_write(18'h15A5A, 2'd1);
    chk(frame_err, "R6 sticky after good word", frame_err, 1);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0; @(negedge clk);
    chk(!frame_err, "R6 cleared", frame_err, 0);
  endtask

  task automatic t_short();
    shift_bits(32'h1B3C5, 18);
    load();
    check_all("R5 short word");
    chk(frame_err, "R6 short sets error", frame_err, 1);
  endtask

  task automatic t_latency();
    shift_bits({18'h0F0F0, 2'd2}, 20);
    ser_le = 1;
    repeat (4) @(negedge clk);
    chk(cfg_q[2] == 18'h0F0F0, "R8 latency", 32'(cfg_q[2]), 32'h0F0F0);
    ser_le = 0;
    repeat (4) @(negedge clk);
    exp_cfg[2] = 18'h0F0F0;
  endtask

  task automatic t_reset_again();
    rst = 1; repeat (2) @(negedge clk); rst = 0; @(negedge clk);
    chk(cfg_q == '0, "R7 second reset latches", 32'(cfg_q[2]), 0);
    chk(!frame_err, "R7 second reset error", frame_err, 0);
    model = '0; exp_cfg = '0;
  endtask

  initial begin
    t_reset();
    t_write(18'h2A5C3, 2'd0);
    t_write(18'h3FFFF, 2'd3);
    t_write(18'h00001, 2'd2);
    t_write(18'h20000, 2'd1);
    chk(!frame_err, "R6 no error on good words", frame_err, 0);
    t_long();
    t_sticky_clear();
    t_short();
    t_latency();
    t_reset_again();
    t_write(18'h12345, 2'd3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule